// File: doc/BRIEF.md
# Shared Display Memory Access Arbiter

This block lets a CPU and the video refresh logic share one display refresh RAM. Each character time is split into two halves. In one half the CPU may use the RAM. In the other half the refresh logic owns it. The block decodes the CPU bus strobes to tell apart program memory cycles and display memory cycles. It selects which side drives the RAM address lines.

Sometimes a display memory cycle collides with the refresh half. In that case the block pulls the CPU wait line low. The CPU then holds its address, data and strobes until the CPU half returns, and only then completes the transfer.

A display cycle is first detected as a rising request. That request starts a short fixed-length low pulse. The pulse is built from a shift register that reloads whenever the request goes away. If any part of this pulse falls in the refresh half, a hold flop latches the stall. The hold flop keeps the stall until the CPU half begins again.

Top module: `disp_mem_arbiter`

## Requirements
- R1: `ram_sel` is 1 exactly when `mreq_n`=0, `m1_n`=1, `a15`=1, at least one of `rd_n`/`wr_n` is 0, and the CPU phase is current (`share_phase`=1). In every other case it is 0.
- R2: `prog_en` is 1 exactly when `mreq_n`=0, `rd_n`=0 and `a15`=0, whatever `m1_n` is. It is 0 whenever `a15`=1.
- R3: `addr_src` is 1 (the CPU drives the RAM address) while `share_phase`=1. It is 0 (refresh drives the address) while `share_phase`=0.
- R4: Consider a display access (`mreq_n`=0, `m1_n`=1, `a15`=1) that starts in the CPU phase and completes before its pulse window of PULSE_LEN cycles reaches a refresh-phase cycle. Such an access never sees `wait_n` low.
- R5: The pulse window covers the PULSE_LEN cycles that follow the first clock edge at which a display access is sampled. Take a display access detected during the refresh phase. `wait_n` goes low in the cycle after that edge. It stays low through the first CPU-phase cycle. It returns high in the second CPU-phase cycle.
- R6: A display access may start in the CPU phase while its pulse window is still open when the refresh phase begins. Such an access sees `wait_n` held low from the first refresh cycle until the cycle after the CPU phase returns.
- R7: When the display request drops for at least one clock edge, the detector returns to its load state. The next display request then starts a fresh pulse window, so back-to-back accesses are each judged on their own.
- R8: `ram_sel` is never 1 in a cycle where `share_phase`=0.
- R9: `wait_n` only goes from 1 to 0 in a refresh-phase cycle.
- R10: During reset (`rst_n`=0) with an idle bus, `wait_n`=1, `ram_sel`=0 and `prog_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq_n | input | 1 | Memory request from the CPU, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge cycle marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a15 | input | 1 | Address bit 15; 1 selects display RAM, 0 selects program memory |
| share_phase | input | 1 | Character-slot phase: 1 = CPU half, 0 = refresh half |
| wait_n | output | 1 | Wait request to the CPU, active low |
| ram_sel | output | 1 | Display RAM select for a CPU transfer |
| addr_src | output | 1 | RAM address source: 1 = CPU, 0 = refresh counter |
| prog_en | output | 1 | Program memory read enable |

## Verification
Two events can land in the same cycle: the first refresh cycle of a character slot and the open pulse window of a display access that began late in the CPU half. The bench provokes this by aligning an access to the last CPU-phase positions of the slot. It also starts accesses in the middle of the refresh half and issues two accesses separated by a single idle edge. A behavioural model tracks request age and the latched stall, and is compared on every cycle against all four outputs. Directed checks confirm whether each access was stalled at all.

// File: rtl/disp_mem_arbiter_pkg.sv
package disp_mem_arbiter_pkg;

   typedef enum logic {
      SRC_REFRESH = 1'b0,
      SRC_CPU     = 1'b1
   } addr_src_e;

   typedef struct packed {
      logic disp_req;   // display memory cycle in progress
      logic prog_rd;    // program memory read
      logic strobe;     // read or write strobe active
   } bus_dec_t;

endpackage

// File: rtl/dma_phase_sync.sv
module dma_phase_sync #(
   parameter int STAGES    = 0,
   parameter bit CPU_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic share_phase,
   output logic cpu_phase
);
   generate
      if (STAGES == 0) begin : g_direct
         assign cpu_phase = (share_phase == CPU_LEVEL);
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= {STAGES{~CPU_LEVEL}};
            end else if (STAGES == 1) begin
               sync_q <= share_phase;
            end else begin
               sync_q <= {sync_q[STAGES-2:0], share_phase};
            end
         end
         assign cpu_phase = (sync_q[STAGES-1] == CPU_LEVEL);
      end
   endgenerate
endmodule

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
   import disp_mem_arbiter_pkg::*;
(
   input  logic     mreq_n,
   input  logic     m1_n,
   input  logic     rd_n,
   input  logic     wr_n,
   input  logic     a15,
   output bus_dec_t dec
);
   always_comb begin
      dec.disp_req = ~mreq_n & m1_n & a15;
      dec.prog_rd  = ~mreq_n & ~rd_n & ~a15;
      dec.strobe   = ~rd_n | ~wr_n;
   end
endmodule

// File: rtl/dma_pulse_shifter.sv
module dma_pulse_shifter #(
   parameter int LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse_active
);
   logic [LEN-1:0] sreg_q;
   logic           armed_q;

   generate
      if (LEN == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n || !req) begin
               sreg_q  <= 1'b1;
               armed_q <= 1'b1;
            end else if (armed_q) begin
               sreg_q  <= 1'b0;
               armed_q <= 1'b0;
            end else begin
               sreg_q  <= 1'b1;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n || !req) begin
               sreg_q  <= {LEN{1'b1}};
               armed_q <= 1'b1;
            end else if (armed_q) begin
               sreg_q  <= {LEN{1'b0}};
               armed_q <= 1'b0;
            end else begin
               sreg_q  <= {sreg_q[LEN-2:0], 1'b1};
            end
         end
      end
   endgenerate

   assign pulse_active = ~sreg_q[LEN-1];
endmodule

// File: rtl/dma_stall_hold.sv
module dma_stall_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_phase,
   input  logic pulse_active,
   output logic wait_n
);
   logic hold_q;
   logic collide;

   assign collide = pulse_active & ~cpu_phase;

   always_ff @(posedge clk) begin
      if (!rst_n || cpu_phase) begin
         hold_q <= 1'b0;
      end else if (collide) begin
         hold_q <= 1'b1;
      end
   end

   assign wait_n = ~(hold_q | collide);
endmodule

// File: rtl/disp_mem_arbiter.sv
module disp_mem_arbiter
   import disp_mem_arbiter_pkg::*;
#(
   parameter int PULSE_LEN   = 3,
   parameter int SYNC_STAGES = 0,
   parameter bit CPU_LEVEL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mreq_n,
   input  logic m1_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic a15,
   input  logic share_phase,
   output logic wait_n,
   output logic ram_sel,
   output logic addr_src,
   output logic prog_en
);
   localparam int MaxSync = 3;

   if (PULSE_LEN < 1 || PULSE_LEN > 16) begin : g_bad_len
      $error("PULSE_LEN must be within 1..16");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > MaxSync) begin : g_bad_sync
      $error("SYNC_STAGES must be within 0..3");
   end

   bus_dec_t  dec;
   logic      cpu_phase;
   logic      disp_req;
   logic      pulse_active;
   addr_src_e src;

   dma_phase_sync #(.STAGES(SYNC_STAGES), .CPU_LEVEL(CPU_LEVEL)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .share_phase (share_phase),
      .cpu_phase   (cpu_phase)
   );

   dma_bus_decode u_dec (
      .mreq_n (mreq_n),
      .m1_n   (m1_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .a15    (a15),
      .dec    (dec)
   );

   assign disp_req = dec.disp_req;

   dma_pulse_shifter #(.LEN(PULSE_LEN)) u_pulse (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (disp_req),
      .pulse_active (pulse_active)
   );

   dma_stall_hold u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_phase    (cpu_phase),
      .pulse_active (pulse_active),
      .wait_n       (wait_n)
   );

   assign src      = cpu_phase ? SRC_CPU : SRC_REFRESH;
   assign addr_src = src;
   assign ram_sel  = disp_req & dec.strobe & (src == SRC_CPU);
   assign prog_en  = dec.prog_rd;
endmodule

// File: rtl/disp_mem_arbiter_chk.sv
module disp_mem_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic cpu_phase,
   input logic disp_req,
   input logic pulse_active,
   input logic wait_n,
   input logic ram_sel,
   input logic addr_src
);
   // R5
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_req) |=> pulse_active);

   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_req |=> !pulse_active);

   // R6
   collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_phase && pulse_active) |=> (!wait_n || cpu_phase));

   // R9
   wait_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> !cpu_phase);

   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_phase && $past(cpu_phase)) |-> wait_n);

   // R8
   grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_sel |-> addr_src);
endmodule

bind disp_mem_arbiter disp_mem_arbiter_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_phase    (cpu_phase),
   .disp_req     (disp_req),
   .pulse_active (pulse_active),
   .wait_n       (wait_n),
   .ram_sel      (ram_sel),
   .addr_src     (addr_src)
);

// File: tb/disp_mem_arbiter_tb.sv
module disp_mem_arbiter_tb;
   localparam int PLEN = 3;
   localparam int SLOT = 12;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mreq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a15 = 1'b0;
   logic share_phase = 1'b1;
   logic wait_n, ram_sel, addr_src, prog_en;

   int checks = 0;
   int errors = 0;
   int ph_cnt = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   disp_mem_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n),
      .rd_n(rd_n), .wr_n(wr_n), .a15(a15), .share_phase(share_phase),
      .wait_n(wait_n), .ram_sel(ram_sel), .addr_src(addr_src), .prog_en(prog_en)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // reference model: age of the current display request and latched stall
   int  age = 0;
   bit  held = 1'b0;
   logic prev_wait = 1'b1;

   function automatic bit in_win(input int a);
      return (a >= 1) && (a <= PLEN);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         age  <= 0;
         held <= 1'b0;
      end else begin
         if (share_phase) held <= 1'b0;
         else if (held || in_win(age)) held <= 1'b1;
         if (!(!mreq_n && m1_n && a15)) age <= 0;
         else if (age < 1000) age <= age + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 wait_n", wait_n, !(held || (!share_phase && in_win(age))));
         chk("R1 ram_sel", ram_sel, !mreq_n && m1_n && a15 && (!rd_n || !wr_n) && share_phase);
         chk("R2 prog_en", prog_en, !mreq_n && !rd_n && !a15);
         chk("R3 addr_src", addr_src, share_phase);
         if (ram_sel && !share_phase) chk("R8 ram_sel in refresh", ram_sel, 1'b0);
         if (prev_wait && !wait_n && share_phase) chk("R9 wait fall in CPU phase", wait_n, 1'b1);
         prev_wait = wait_n;
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
      ph_cnt++;
      share_phase = (ph_cnt % SLOT) < HALF;
   endtask

   task automatic align(input int pos);
      while ((ph_cnt % SLOT) != pos) tick();
   endtask

   // CPU bus cycle: holds strobes at least 3 cycles and until wait_n is released
   task automatic access(input logic hi, input logic fetch, input logic wr, output bit stalled);
      int n = 0;
      stalled = 1'b0;
      mreq_n = 1'b0; a15 = hi; m1_n = !fetch;
      rd_n = wr; wr_n = !wr;
      forever begin
         @(negedge clk);
         if (!wait_n) stalled = 1'b1;
         if (n >= 2 && wait_n) break;
         tick();
         n++;
      end
      tick();
      mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; a15 = 1'b0;
   endtask

   initial begin
      bit s1, s2;
      // R10 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 wait_n in reset", wait_n, 1'b1);
      chk("R10 ram_sel in reset", ram_sel, 1'b0);
      chk("R10 prog_en in reset", prog_en, 1'b0);
      #2 rst_n = 1'b1;
      repeat (4) tick();

      // R4 display read in CPU phase, fits in the half
      align(0);
      access(1'b1, 1'b0, 1'b0, s1);
      chk("R4 no stall in CPU phase", s1, 1'b0);

      // R5 display read starting mid refresh
      align(7);
      access(1'b1, 1'b0, 1'b0, s1);
      chk("R5 stall from refresh", s1, 1'b1);

      // R6 display write starting at end of CPU phase, window crosses into refresh
      align(4);
      access(1'b1, 1'b0, 1'b1, s1);
      chk("R6 stall across phase edge", s1, 1'b1);

      // R2 program fetch and read, never stalled
      align(8);
      access(1'b0, 1'b1, 1'b0, s1);
      chk("R2 program fetch no stall", s1, 1'b0);
      align(1);
      access(1'b0, 1'b0, 1'b0, s1);
      chk("R2 program read no stall", s1, 1'b0);

      // R7 back-to-back: first in CPU phase, second after one idle edge lands in refresh
      align(0);
      access(1'b1, 1'b0, 1'b0, s1);
      tick();
      access(1'b1, 1'b0, 1'b1, s2);
      chk("R7 first access not stalled", s1, 1'b0);
      chk("R7 second access stalled", s2, 1'b1);

      // R7 back-to-back both in refresh
      align(6);
      access(1'b1, 1'b0, 1'b0, s1);
      align(6);
      tick();
      access(1'b1, 1'b0, 1'b1, s2);
      chk("R7 refresh pair first", s1, 1'b1);
      chk("R7 refresh pair second", s2, 1'b1);

      // R1 fetch cycle at a15=1 is not a display access
      align(2);
      access(1'b1, 1'b1, 1'b0, s1);
      chk("R1 fetch at a15 high ignored", s1, 1'b0);

      repeat (SLOT) tick();
      done = 1'b1;
   end

   initial begin
      int wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule